// File: doc/BRIEF.md
# Cascaded Programmable Biquad Filter Chain

This block is the per-channel digital filtering stage that follows a decimation front end. It takes one signed 16-bit sample at a time and scales it by a signed fine gain that covers the range from -4 to just under +4. The scaled value then passes through seven second-order IIR sections in series, section 0 first and section 6 last. Together the seven sections form a 14th-order filter. The coefficients of a section set its response: low-pass, high-pass or band-pass. Each section also has a pass-through switch and an optional absolute-value (rectify) step.

The arithmetic runs on one shared multiplier and one accumulator. The gain step takes one cycle. Each section then takes five multiply-accumulate cycles, one for each coefficient. A result leaves the block a fixed number of cycles after its sample was accepted. Coefficients, section modes and the gain are loaded through a simple write port into a staging copy. The staging copy moves into the working copy only when a new sample is accepted. A sample that is in flight therefore always uses a complete, consistent parameter set.

Top module: `biq_chain`

## Requirements
- R1: After reset `out_valid` is low and every parameter is at its default. For each section the defaults are b0 = 1.0 (16384), b1 = b2 = a1 = a2 = 0, filtering enabled and rectify off. The gain defaults to 1.0 (8192) and all section history is zero. A sample sent right after reset therefore comes out unchanged.
- R2: The gain is a signed 16-bit Q3.13 value, so 0x8000 means -4.0 and 0x2000 means 1.0. The gain stage forms the product of sample and gain and shifts it arithmetically right by 13, rounding toward minus infinity. It then saturates the result to [-32768, 32767].
- R3: An enabled section computes y = sat((b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2) >>> 14).
  - The coefficients are signed Q2.14 values.
  - x1 and x2 are the section's previous two inputs, and y1 and y2 are its previous two saturated filter results.
  - The full sum is formed in a wide accumulator before the shift and the saturation.
  - The history carries over from one sample to the next.
- R4: Mode bit 0 selects filtering (1) or pass-through (0). In pass-through the section output equals its input and the section history is left unchanged.
- R5: Mode bit 1 = 1 replaces the section output with its absolute value, and -32768 becomes 32767. This applies in both filter and pass-through modes. With rectify on in section 6, no output is negative.
- R6: The sections run strictly in series, in the order 0 to 6. The output of each section, after rectify, is the input of the next.
- R7: `out_valid` is a single-cycle pulse. Its cycle comes exactly 36 clock cycles after the cycle in which the sample was accepted, so a sample accepted in cycle c produces its result in cycle c+36. The block can accept the next sample in that same result cycle.
- R8: A sample is accepted when `in_valid` is high and no sample is in flight. A sample presented while one is in flight is dropped and has no effect on any output or on any history.
- R9: A write takes `cfg_addr` = {section[5:3], field[2:0]}, with fields 0..4 = b0, b1, b2, a1, a2 and field 5 = mode.
  - The address {7, 0} holds the gain.
  - A write goes to the staging copy. It takes effect from the next sample accepted after the write cycle.
  - A write made in the cycle in which a sample is accepted does not apply to that sample.
- R10: Writes to unmapped addresses have no effect. These are fields 6 and 7 of sections 0 to 6, and fields 1 to 7 of section 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | 6 | {section, field} parameter address |
| cfg_data | input | 16 | Parameter write value |
| out_valid | output | 1 | Output sample strobe, one cycle |
| out_data | output | 16 | Signed filtered sample |

## Verification
The hardest conditions to reach from the ports involve timing: a parameter write that lands while a sample is half-way through the seven sections, or in the exact cycle a sample is accepted. A second such condition is a sample that arrives while the chain is still busy. The stimulus creates these with writes and strobes placed at chosen offsets after a sample is sent. It also holds `in_valid` high for many cycles, so acceptance falls on the earliest legal cycle again and again. The feedback history is driven into saturation with near-2.0 coefficients and full-scale inputs. Pass-through is switched on and off between samples to show that the history stays frozen while a section is bypassed.

// File: rtl/biq_pkg.sv
`timescale 1ns/1ps
package biq_pkg;

   // number of coefficients per second-order section
   localparam int NTAP = 5;
   // width of the field part of a parameter address
   localparam int FLDW = 3;

   typedef enum logic [2:0] {
      FLD_B0   = 3'd0,
      FLD_B1   = 3'd1,
      FLD_B2   = 3'd2,
      FLD_A1   = 3'd3,
      FLD_A2   = 3'd4,
      FLD_MODE = 3'd5
   } fld_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_GAIN = 2'd1,
      SQ_MAC  = 2'd2
   } seq_e;

   typedef struct packed {
      logic rect;
      logic en;
   } mode_t;

endpackage

// File: rtl/biq_coef_bank.sv
`timescale 1ns/1ps
// Staged and working copies of all section coefficients, modes and the gain.
module biq_coef_bank
   import biq_pkg::*;
#(
   parameter int NSEC  = 7,
   parameter int CW    = 16,
   parameter int CFRAC = 14,
   parameter int GFRAC = 13,
   parameter int SECW  = 3
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [SECW-1:0]      wr_sec,
   input  logic [FLDW-1:0]      wr_fld,
   input  logic [CW-1:0]        wr_data,
   input  logic                 commit,
   input  logic [SECW-1:0]      rd_sec,
   input  logic [2:0]           rd_tap,
   output logic signed [CW-1:0] coef,
   output logic signed [CW-1:0] gain,
   output logic [NSEC-1:0]      en_vec,
   output logic [NSEC-1:0]      rect_vec
);

   localparam logic [CW-1:0] ONE_C = {{(CW-1){1'b0}}, 1'b1} << CFRAC;
   localparam logic [CW-1:0] ONE_G = {{(CW-1){1'b0}}, 1'b1} << GFRAC;
   localparam mode_t MODE_DFLT = '{rect: 1'b0, en: 1'b1};

   logic signed [CW-1:0] act_flat [NSEC][NTAP];

   for (genvar s = 0; s < NSEC; s++) begin : g_sec
      for (genvar t = 0; t < NTAP; t++) begin : g_tap
         localparam logic [CW-1:0] DFLT = (t == 0) ? ONE_C : '0;
         logic [CW-1:0] stg_q;
         logic [CW-1:0] act_q;
         logic          hit;
         assign hit = wr_en && (wr_sec == SECW'(s)) && (wr_fld == FLDW'(t));
         always_ff @(posedge clk) begin
            if (rst) begin
               stg_q <= DFLT;
               act_q <= DFLT;
            end else begin
               if (commit) act_q <= stg_q;
               if (hit)    stg_q <= wr_data;
            end
         end
         assign act_flat[s][t] = $signed(act_q);
      end

      mode_t m_stg;
      mode_t m_act;
      logic  m_hit;
      assign m_hit = wr_en && (wr_sec == SECW'(s)) && (wr_fld == FLD_MODE);
      always_ff @(posedge clk) begin
         if (rst) begin
            m_stg <= MODE_DFLT;
            m_act <= MODE_DFLT;
         end else begin
            if (commit) m_act <= m_stg;
            if (m_hit)  m_stg <= mode_t'(wr_data[1:0]);
         end
      end
      assign en_vec[s]   = m_act.en;
      assign rect_vec[s] = m_act.rect;
   end

   // gain lives at section index NSEC, field 0
   logic [CW-1:0] g_stg;
   logic [CW-1:0] g_act;
   logic          g_hit;
   assign g_hit = wr_en && (wr_sec == SECW'(NSEC)) && (wr_fld == FLD_B0);
   always_ff @(posedge clk) begin
      if (rst) begin
         g_stg <= ONE_G;
         g_act <= ONE_G;
      end else begin
         if (commit) g_act <= g_stg;
         if (g_hit)  g_stg <= wr_data;
      end
   end
   assign gain = $signed(g_act);

   always_comb begin
      if (rd_tap < 3'(NTAP)) coef = act_flat[rd_sec][rd_tap];
      else                   coef = '0;
   end

endmodule

// File: rtl/biq_history.sv
`timescale 1ns/1ps
// Direct-form I delay lines, two inputs and two outputs per section.
module biq_history #(
   parameter int NSEC = 7,
   parameter int DW   = 16,
   parameter int SECW = 3
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 upd,
   input  logic [SECW-1:0]      sec,
   input  logic signed [DW-1:0] xin,
   input  logic signed [DW-1:0] yin,
   output logic signed [DW-1:0] hx1,
   output logic signed [DW-1:0] hx2,
   output logic signed [DW-1:0] hy1,
   output logic signed [DW-1:0] hy2
);

   logic signed [DW-1:0] x1_f [NSEC];
   logic signed [DW-1:0] x2_f [NSEC];
   logic signed [DW-1:0] y1_f [NSEC];
   logic signed [DW-1:0] y2_f [NSEC];

   for (genvar s = 0; s < NSEC; s++) begin : g_line
      logic signed [DW-1:0] x1_q, x2_q, y1_q, y2_q;
      logic                 hit;
      assign hit = upd && (sec == SECW'(s));
      always_ff @(posedge clk) begin
         if (rst) begin
            x1_q <= '0;
            x2_q <= '0;
            y1_q <= '0;
            y2_q <= '0;
         end else if (hit) begin
            x2_q <= x1_q;
            x1_q <= xin;
            y2_q <= y1_q;
            y1_q <= yin;
         end
      end
      assign x1_f[s] = x1_q;
      assign x2_f[s] = x2_q;
      assign y1_f[s] = y1_q;
      assign y2_f[s] = y2_q;
   end

   assign hx1 = x1_f[sec];
   assign hx2 = x2_f[sec];
   assign hy1 = y1_f[sec];
   assign hy2 = y2_f[sec];

endmodule

// File: rtl/biq_mac.sv
`timescale 1ns/1ps
// Shared multiplier, wide accumulator and the two rescale-and-clip paths.
module biq_mac #(
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int CFRAC = 14,
   parameter int GFRAC = 13,
   parameter int ACCW  = 40
)(
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   clr,
   input  logic                   sub,
   input  logic signed [DW-1:0]   opa,
   input  logic signed [CW-1:0]   opb,
   output logic signed [ACCW-1:0] acc_sum,
   output logic signed [DW-1:0]   sec_res,
   output logic signed [DW-1:0]   gain_res
);

   localparam int PW = DW + CW;
   localparam logic signed [ACCW-1:0] HI = ACCW'({1'b0, {(DW-1){1'b1}}});
   localparam logic signed [ACCW-1:0] LO = ~HI;

   function automatic logic signed [DW-1:0] clip(input logic signed [ACCW-1:0] v);
      if (v > HI)      return HI[DW-1:0];
      else if (v < LO) return LO[DW-1:0];
      else             return v[DW-1:0];
   endfunction

   logic signed [PW-1:0]   prod;
   logic signed [ACCW-1:0] prod_x;
   logic signed [ACCW-1:0] acc_q;
   logic signed [ACCW-1:0] sec_sh;
   logic signed [ACCW-1:0] gain_sh;

   assign prod    = opa * opb;
   assign prod_x  = {{(ACCW-PW){prod[PW-1]}}, prod};
   assign acc_sum = sub ? (acc_q - prod_x) : (acc_q + prod_x);
   assign sec_sh  = acc_sum >>> CFRAC;
   assign gain_sh = prod_x >>> GFRAC;
   assign sec_res  = clip(sec_sh);
   assign gain_res = clip(gain_sh);

   always_ff @(posedge clk) begin
      if (rst || clr) acc_q <= '0;
      else            acc_q <= acc_sum;
   end

endmodule

// File: rtl/biq_chain.sv
`timescale 1ns/1ps
// Fine gain followed by NSEC time-shared direct-form I biquads in series.
module biq_chain
   import biq_pkg::*;
#(
   parameter int NSEC  = 7,
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int CFRAC = 14,
   parameter int GFRAC = 13,
   parameter int ACCW  = 40,
   localparam int SECW  = $clog2(NSEC + 1),
   localparam int ADDRW = SECW + FLDW,
   localparam int LAT   = 1 + NTAP * NSEC
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_data,
   input  logic                 cfg_we,
   input  logic [ADDRW-1:0]     cfg_addr,
   input  logic [CW-1:0]        cfg_data,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_data
);

   if (NSEC < 1) begin : g_bad_nsec
      $error("biq_chain: NSEC must be at least 1");
   end
   if (CFRAC > CW - 2) begin : g_bad_cfrac
      $error("biq_chain: coefficients need two integer bits");
   end
   if (GFRAC > CW - 3) begin : g_bad_gfrac
      $error("biq_chain: gain needs three integer bits");
   end
   if (ACCW < DW + CW + 4) begin : g_bad_accw
      $error("biq_chain: accumulator too narrow for five products");
   end

   function automatic logic signed [DW-1:0] mag(input logic signed [DW-1:0] v);
      if (v == {1'b1, {(DW-1){1'b0}}}) return {1'b0, {(DW-1){1'b1}}};
      else if (v[DW-1])                return -v;
      else                             return v;
   endfunction

   seq_e                 st;
   logic [SECW-1:0]      sec;
   logic [2:0]           tap;
   logic signed [DW-1:0] cur;
   logic                 commit;
   logic                 last_tap;
   logic                 last_sec;
   logic                 sec_done;
   logic                 seq_idle;

   logic signed [CW-1:0]   coef;
   logic signed [CW-1:0]   gain;
   logic [NSEC-1:0]        en_vec;
   logic [NSEC-1:0]        rect_vec;
   logic signed [DW-1:0]   hx1, hx2, hy1, hy2;
   logic signed [DW-1:0]   opa;
   logic signed [CW-1:0]   opb;
   logic signed [ACCW-1:0] acc_sum;
   logic signed [DW-1:0]   sec_res;
   logic signed [DW-1:0]   gain_res;
   logic signed [DW-1:0]   pick;
   logic signed [DW-1:0]   stage_out;
   logic                   mac_clr;
   logic                   mac_sub;
   logic                   hist_upd;

   assign seq_idle = (st == SQ_IDLE);
   assign commit   = seq_idle && in_valid;
   assign last_tap = (tap == 3'(NTAP - 1));
   assign last_sec = (sec == SECW'(NSEC - 1));
   assign sec_done = (st == SQ_MAC) && last_tap;

   biq_coef_bank #(
      .NSEC(NSEC), .CW(CW), .CFRAC(CFRAC), .GFRAC(GFRAC), .SECW(SECW)
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we),
      .wr_sec  (cfg_addr[ADDRW-1:FLDW]),
      .wr_fld  (cfg_addr[FLDW-1:0]),
      .wr_data (cfg_data),
      .commit  (commit),
      .rd_sec  (sec),
      .rd_tap  (tap),
      .coef    (coef),
      .gain    (gain),
      .en_vec  (en_vec),
      .rect_vec(rect_vec)
   );

   biq_history #(
      .NSEC(NSEC), .DW(DW), .SECW(SECW)
   ) u_hist (
      .clk (clk),
      .rst (rst),
      .upd (hist_upd),
      .sec (sec),
      .xin (cur),
      .yin (sec_res),
      .hx1 (hx1),
      .hx2 (hx2),
      .hy1 (hy1),
      .hy2 (hy2)
   );

   always_comb begin
      unique case (tap)
         3'd0:    opa = cur;
         3'd1:    opa = hx1;
         3'd2:    opa = hx2;
         3'd3:    opa = hy1;
         default: opa = hy2;
      endcase
      if (st != SQ_MAC) opa = cur;
   end

   assign opb     = (st == SQ_MAC) ? coef : gain;
   assign mac_clr = (st != SQ_MAC) || last_tap;
   assign mac_sub = (st == SQ_MAC) && (tap >= 3'(FLD_A1));

   biq_mac #(
      .DW(DW), .CW(CW), .CFRAC(CFRAC), .GFRAC(GFRAC), .ACCW(ACCW)
   ) u_mac (
      .clk     (clk),
      .rst     (rst),
      .clr     (mac_clr),
      .sub     (mac_sub),
      .opa     (opa),
      .opb     (opb),
      .acc_sum (acc_sum),
      .sec_res (sec_res),
      .gain_res(gain_res)
   );

   assign pick      = en_vec[sec] ? sec_res : cur;
   assign stage_out = rect_vec[sec] ? mag(pick) : pick;
   assign hist_upd  = sec_done && en_vec[sec];

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= SQ_IDLE;
         sec       <= '0;
         tap       <= '0;
         cur       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (in_valid) begin
                  cur <= in_data;
                  st  <= SQ_GAIN;
               end
            end
            SQ_GAIN: begin
               cur <= gain_res;
               sec <= '0;
               tap <= '0;
               st  <= SQ_MAC;
            end
            SQ_MAC: begin
               if (last_tap) begin
                  cur <= stage_out;
                  tap <= '0;
                  if (last_sec) begin
                     st        <= SQ_IDLE;
                     out_valid <= 1'b1;
                     out_data  <= stage_out;
                  end else begin
                     sec <= sec + 1'b1;
                  end
               end else begin
                  tap <= tap + 1'b1;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/biq_chain_chk.sv
`timescale 1ns/1ps
// Temporal checks for biq_chain, attached by bind.
module biq_chain_chk #(
   parameter int DW  = 16,
   parameter int LAT = 36
)(
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          out_valid,
   input logic [DW-1:0] out_data,
   input logic          seq_idle,
   input logic          last_rect
);

   localparam int CNTW = $clog2(LAT + 1);

   logic            run;
   logic [CNTW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (seq_idle && in_valid) begin
         run <= 1'b1;
         cnt <= '0;
      end else if (run) begin
         if (cnt == CNTW'(LAT)) run <= 1'b0;
         else                   cnt <= cnt + 1'b1;
      end
   end

   // R1: reset leaves no output strobe
   assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !out_valid);

   // R7: result strobe appears exactly LAT cycles after acceptance
   assert_latency_hit_R7: assert property (@(posedge clk) disable iff (rst)
      (run && cnt == CNTW'(LAT)) |-> out_valid);

   // R7/R8: no strobe without an accepted sample at the right distance
   assert_no_stray_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (run && cnt == CNTW'(LAT)));

   // R7: single-cycle output pulse
   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R5: rectified last section never emits a negative value
   assert_rect_nonneg_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && last_rect) |-> !out_data[DW-1]);

endmodule

bind biq_chain biq_chain_chk #(.DW(DW), .LAT(LAT)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .out_valid(out_valid),
   .out_data (out_data),
   .seq_idle (seq_idle),
   .last_rect(rect_vec[NSEC-1])
);

// File: tb/tb_biq_chain.sv
`timescale 1ns/1ps
module tb_biq_chain;

   localparam int LATC = 36;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               cfg_we = 1'b0;
   logic [5:0]         cfg_addr = '0;
   logic [15:0]        cfg_data = '0;
   logic               out_valid;
   logic signed [15:0] out_data;

   always #2.5 clk = ~clk;

   biq_chain dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string req = "R1";
   bit    chk_on = 0;
   bit    done = 0;

   // ---------------- behavioural reference ----------------
   int     sc [7][5];
   int     ac [7][5];
   bit     se [7], ae [7], sr [7], ar [7];
   int     sg, ag;
   longint hx1 [7], hx2 [7], hy1 [7], hy2 [7];
   bit     busy;
   int     cnt;
   longint res;
   bit     exp_v;
   longint exp_d;

   function automatic longint sat16(longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic void mreset();
      for (int s = 0; s < 7; s++) begin
         for (int t = 0; t < 5; t++) begin
            sc[s][t] = (t == 0) ? 16384 : 0;
            ac[s][t] = sc[s][t];
         end
         se[s] = 1; ae[s] = 1; sr[s] = 0; ar[s] = 0;
         hx1[s] = 0; hx2[s] = 0; hy1[s] = 0; hy2[s] = 0;
      end
      sg = 8192; ag = 8192;
      busy = 0; cnt = 0; exp_v = 0; exp_d = 0;
   endfunction

   function automatic void mwrite(logic [5:0] a, logic [15:0] d);
      int s, f;
      s = int'(a[5:3]);
      f = int'(a[2:0]);
      if (s < 7) begin
         if (f < 5) sc[s][f] = int'($signed(d));
         else if (f == 5) begin se[s] = d[0]; sr[s] = d[1]; end
      end else if (f == 0) begin
         sg = int'($signed(d));
      end
   endfunction

   function automatic longint mrun(longint x);
      longint v, acc, f;
      v = sat16((x * longint'(ag)) >>> 13);
      for (int s = 0; s < 7; s++) begin
         if (ae[s]) begin
            acc = longint'(ac[s][0]) * v + longint'(ac[s][1]) * hx1[s]
                + longint'(ac[s][2]) * hx2[s] - longint'(ac[s][3]) * hy1[s]
                - longint'(ac[s][4]) * hy2[s];
            f = sat16(acc >>> 14);
            hx2[s] = hx1[s]; hx1[s] = v;
            hy2[s] = hy1[s]; hy1[s] = f;
            v = f;
         end
         if (ar[s] && v < 0) v = (v == -32768) ? 32767 : -v;
      end
      return v;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         mreset();
      end else begin
         exp_v = 0;
         if (busy) begin
            cnt--;
            if (cnt == 0) begin exp_v = 1; exp_d = res; busy = 0; end
         end else if (in_valid) begin
            for (int s = 0; s < 7; s++) begin
               for (int t = 0; t < 5; t++) ac[s][t] = sc[s][t];
               ae[s] = se[s]; ar[s] = sr[s];
            end
            ag = sg;
            res = mrun(longint'(in_data));
            cnt = LATC;
            busy = 1;
         end
         if (cfg_we) mwrite(cfg_addr, cfg_data);
      end
   end

   // ---------------- checking ----------------
   task automatic chk(bit ok, string what, longint act, longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on && !rst) begin
         chk(out_valid === exp_v, "out_valid", longint'(out_valid), longint'(exp_v));
         if (exp_v)
            chk(longint'(out_data) == exp_d, "out_data", longint'(out_data), exp_d);
      end
   end

   // ---------------- stimulus ----------------
   task automatic send(int x);
      @(negedge clk); in_valid = 1; in_data = 16'(x);
      @(negedge clk); in_valid = 0;
      repeat (40) @(negedge clk);
   endtask

   task automatic wr(int s, int f, int d);
      @(negedge clk); cfg_we = 1; cfg_addr = {3'(s), 3'(f)}; cfg_data = 16'(d);
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic set_sec(int s, int b0, int b1, int b2, int a1, int a2, int m);
      wr(s, 0, b0); wr(s, 1, b1); wr(s, 2, b2); wr(s, 3, a1); wr(s, 4, a2); wr(s, 5, m);
   endtask

   task automatic restore_all();
      for (int s = 0; s < 7; s++) set_sec(s, 16384, 0, 0, 0, 0, 1);
      wr(7, 0, 8192);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      req = "R1";
      chk(out_valid === 1'b0, "reset out_valid", longint'(out_valid), 0);
      chk_on = 1;
      send(1234); send(-777); send(32767); send(-32768);

      req = "R2";
      wr(7, 0, 16'h4000); send(20000); send(-100);
      wr(7, 0, 16'h8000); send(1000); send(-32768); send(32767);
      wr(7, 0, 16'h2001); send(12345); send(-3);
      wr(7, 0, 16'h2000);

      req = "R3";
      set_sec(0, 4096, 8192, 4096, -9830, 3277, 1);
      set_sec(1, 8192, -16384, 8192, 0, 0, 1);
      set_sec(2, 4915, 0, -4915, -16384, 8192, 1);
      for (int i = 0; i < 6; i++) send(10000);
      send(0); send(0); send(-20000); send(0); send(0);
      set_sec(3, 32767, 32767, 0, 0, 0, 1);
      send(30000); send(-30000); send(30000);

      req = "R4";
      wr(0, 5, 0); send(5000); send(-5000);
      wr(0, 5, 1); send(7000); send(7000);

      req = "R6";
      restore_all();
      set_sec(4, 8192, 0, 0, 0, 0, 1);
      set_sec(5, 32767, 0, 0, 0, 0, 1);
      send(30000); send(-20000);
      restore_all();
      set_sec(2, 16384, 0, 0, 0, 0, 3);
      set_sec(3, 8192, -8192, 0, 0, 0, 1);
      send(-12000); send(9000);

      req = "R5";
      restore_all();
      wr(6, 5, 3); send(-5000); send(-32768); send(4000);
      wr(6, 5, 2); send(-6000);
      wr(6, 5, 1);

      req = "R7";
      set_sec(0, 4096, 8192, 4096, -9830, 3277, 1);
      @(negedge clk); in_valid = 1;
      for (int i = 0; i < 120; i++) begin
         in_data = 16'(i * 517 - 30000);
         @(negedge clk);
      end
      in_valid = 0;
      repeat (40) @(negedge clk);

      req = "R8";
      @(negedge clk); in_valid = 1; in_data = 16'(3000);
      @(negedge clk); in_valid = 0;
      repeat (9) @(negedge clk);
      in_valid = 1; in_data = 16'(-31000);
      @(negedge clk); in_valid = 0;
      repeat (40) @(negedge clk);
      send(100);

      req = "R9";
      restore_all();
      @(negedge clk); in_valid = 1; in_data = 16'(8000);
      @(negedge clk); in_valid = 0;
      repeat (5) @(negedge clk);
      cfg_we = 1; cfg_addr = {3'd0, 3'd0}; cfg_data = 16'(8192);
      @(negedge clk); cfg_we = 0;
      repeat (40) @(negedge clk);
      send(8000);
      @(negedge clk); in_valid = 1; in_data = 16'(-6000);
      cfg_we = 1; cfg_addr = {3'd7, 3'd0}; cfg_data = 16'h4000;
      @(negedge clk); in_valid = 0; cfg_we = 0;
      repeat (40) @(negedge clk);
      send(-6000);

      req = "R10";
      restore_all();
      wr(7, 3, 16'h1234); wr(7, 5, 3); wr(0, 6, 0); wr(0, 7, 0); wr(6, 7, 2);
      send(-9999); send(4321);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule